// File: doc/BRIEF.md
# Issue-slot loss cause classifier

Each issue cycle, the issue stage of an out-of-order core goes through a short series of checks to see why it issued fewer instructions than it could. This block receives the status behind those checks and reduces it to one 3-bit cause for the cycle. The status comes from a start-of-cycle summary, from each instruction queue as the issue loop visits it, and from a per-thread bandwidth limit. Dependency-producer blame is computed elsewhere and reaches the block as flags.

A pulse on `cycle_start_i` clears the working cause. Events arriving during the cycle write causes under a first-cause-wins rule. The one exception is the start-of-cycle summary, which assigns its cause directly. A pulse on `cycle_end_i` copies the resolved cause, including that clock's events, into a registered output. A valid strobe accompanies it on the following cycle.

Top module: `issue_loss_cause`

## Requirements
- R1: The cause codes are 0 not-set, 1 no-instruction, 2 queue-limited, 3 dependency-wait and 4 bandwidth. After reset `cause_o` is 0 and `cause_valid_o` is 0. On the clock edge where `cycle_end_i` is high, `cause_o` loads the cause as resolved with that clock's events. `cause_valid_o` is high only in the cycle after a `cycle_end_i` clock, and `cause_o` holds otherwise.
- R2: `cycle_start_i` clears the working cause to not-set. Events in the same clock are then applied on top of the cleared value.
- R3: If a summary event (`sum_evt_i`) arrives with a ready count of zero and both queue counts at zero, the cause is no-instruction.
- R4: On a summary with a zero ready count where some instructions exist, the oldest entry is chosen as follows. The LSQ oldest is taken only when its sequence number is strictly smaller than the IQ oldest's, or when the IQ oldest is not valid. On equal sequence numbers the IQ entry is taken.
- R5: If the chosen summary entry has operands ready, the cause is queue-limited. Otherwise the cause is dependency-wait when its blame flag is set, and queue-limited when it is not. This summary assignment overwrites any cause already present.
- R6: A summary event with a nonzero ready count changes nothing.
- R7: A queue event with a non-empty ready list and no bandwidth left gives the bandwidth cause. With bandwidth left, it gives no cause.
- R8: A queue event with an empty ready list gives no-instruction when either no bandwidth is left or the window is empty.
- R9: A queue event with an empty ready list, bandwidth left and a non-empty window gives dependency-wait when that queue's blame flag is set. Otherwise it gives queue-limited.
- R10: Queue and thread-bandwidth events write only while the cause is not-set. Within a clock the summary is applied first, then the queues in ascending index order, then the thread event.
- R11: `thr_bw_i` gives the bandwidth cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cycle_start_i | input | 1 | Clears the working cause |
| cycle_end_i | input | 1 | Publishes the resolved cause |
| sum_evt_i | input | 1 | Start-of-cycle summary event |
| ready_cnt_i | input | CNT_W | Total ready instructions, IQ plus LSQ |
| iq_cnt_i | input | CNT_W | IQ occupancy |
| lsq_cnt_i | input | CNT_W | LSQ occupancy |
| iq_old_vld_i | input | 1 | IQ oldest entry exists |
| iq_old_seq_i | input | SEQ_W | IQ oldest sequence number |
| iq_old_ops_i | input | 1 | IQ oldest operands ready |
| iq_old_blame_i | input | 1 | Producer identified for IQ oldest |
| lsq_old_vld_i | input | 1 | LSQ oldest entry exists |
| lsq_old_seq_i | input | SEQ_W | LSQ oldest sequence number |
| lsq_old_ops_i | input | 1 | LSQ oldest operands ready |
| lsq_old_blame_i | input | 1 | Producer identified for LSQ oldest |
| q_evt_i | input | NUM_Q | Queue visited this clock, one bit per queue |
| q_rdy_ne_i | input | NUM_Q | Ready list non-empty |
| q_bw_avail_i | input | NUM_Q | Issue bandwidth left |
| q_win_ne_i | input | NUM_Q | Window holds instructions |
| q_blame_i | input | NUM_Q | Producer identified for queue oldest |
| thr_bw_i | input | 1 | Thread issue bandwidth exhausted |
| cause_o | output | 3 | Published cause code |
| cause_valid_o | output | 1 | Cause published this cycle |

## Verification
On every cycle, the assertions check four things: the valid strobe follows the end pulse, a cause that is set stays put unless a clear or a summary intervenes, a clear with no events leaves not-set, and an empty summary yields no-instruction. The bench scenarios are needed for the rest. These are the choice of oldest entry on equal and strictly smaller sequence numbers, the blame fallback, the ordering between queues in one clock, and causes that build up across several clocks before publication.

// File: rtl/issue_loss_pkg.sv
package issue_loss_pkg;
  typedef enum logic [2:0] {
    CAUSE_NONE  = 3'd0,
    CAUSE_NOINS = 3'd1,
    CAUSE_QUEUE = 3'd2,
    CAUSE_DEPS  = 3'd3,
    CAUSE_BW    = 3'd4
  } cause_e;
endpackage

// File: rtl/issue_loss_summary.sv
module issue_loss_summary
  import issue_loss_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int SEQ_W = 8
) (
  input  logic             evt_i,
  input  logic [CNT_W-1:0] ready_cnt_i,
  input  logic [CNT_W-1:0] iq_cnt_i,
  input  logic [CNT_W-1:0] lsq_cnt_i,
  input  logic             iq_vld_i,
  input  logic [SEQ_W-1:0] iq_seq_i,
  input  logic             iq_ops_i,
  input  logic             iq_blame_i,
  input  logic             lsq_vld_i,
  input  logic [SEQ_W-1:0] lsq_seq_i,
  input  logic             lsq_ops_i,
  input  logic             lsq_blame_i,
  output logic             hit_o,
  output cause_e           cause_o
);
  logic take_lsq, sel_ops, sel_blame;

  // LSQ wins only when strictly older, or when the IQ has nothing
  assign take_lsq  = !iq_vld_i || (lsq_vld_i && (lsq_seq_i < iq_seq_i));
  assign sel_ops   = take_lsq ? lsq_ops_i   : iq_ops_i;
  assign sel_blame = take_lsq ? lsq_blame_i : iq_blame_i;

  assign hit_o = evt_i && (ready_cnt_i == '0);

  always_comb begin
    if ((iq_cnt_i == '0) && (lsq_cnt_i == '0)) cause_o = CAUSE_NOINS;
    else if (sel_ops)                          cause_o = CAUSE_QUEUE;
    else if (sel_blame)                        cause_o = CAUSE_DEPS;
    else                                       cause_o = CAUSE_QUEUE;
  end
endmodule

// File: rtl/issue_loss_queue.sv
module issue_loss_queue
  import issue_loss_pkg::*;
(
  input  logic   evt_i,
  input  logic   rdy_ne_i,
  input  logic   bw_avail_i,
  input  logic   win_ne_i,
  input  logic   blame_i,
  output logic   prop_vld_o,
  output cause_e prop_o
);
  always_comb begin
    prop_vld_o = 1'b0;
    prop_o     = CAUSE_NONE;
    if (evt_i) begin
      if (rdy_ne_i) begin
        if (!bw_avail_i) begin
          prop_vld_o = 1'b1;
          prop_o     = CAUSE_BW;
        end
      end else if (!bw_avail_i || !win_ne_i) begin
        prop_vld_o = 1'b1;
        prop_o     = CAUSE_NOINS;
      end else begin
        prop_vld_o = 1'b1;
        prop_o     = blame_i ? CAUSE_DEPS : CAUSE_QUEUE;
      end
    end
  end
endmodule

// File: rtl/issue_loss_cause.sv
module issue_loss_cause
  import issue_loss_pkg::*;
#(
  parameter int NUM_Q = 2,
  parameter int CNT_W = 4,
  parameter int SEQ_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cycle_start_i,
  input  logic             cycle_end_i,
  input  logic             sum_evt_i,
  input  logic [CNT_W-1:0] ready_cnt_i,
  input  logic [CNT_W-1:0] iq_cnt_i,
  input  logic [CNT_W-1:0] lsq_cnt_i,
  input  logic             iq_old_vld_i,
  input  logic [SEQ_W-1:0] iq_old_seq_i,
  input  logic             iq_old_ops_i,
  input  logic             iq_old_blame_i,
  input  logic             lsq_old_vld_i,
  input  logic [SEQ_W-1:0] lsq_old_seq_i,
  input  logic             lsq_old_ops_i,
  input  logic             lsq_old_blame_i,
  input  logic [NUM_Q-1:0] q_evt_i,
  input  logic [NUM_Q-1:0] q_rdy_ne_i,
  input  logic [NUM_Q-1:0] q_bw_avail_i,
  input  logic [NUM_Q-1:0] q_win_ne_i,
  input  logic [NUM_Q-1:0] q_blame_i,
  input  logic             thr_bw_i,
  output logic [2:0]       cause_o,
  output logic             cause_valid_o
);
  localparam int NSTG = NUM_Q + 1;

  cause_e cur_q, nxt;
  logic   sum_hit;
  cause_e sum_cause;
  logic   prop_vld [NUM_Q];
  cause_e prop     [NUM_Q];
  cause_e stg      [NSTG];

  issue_loss_summary #(.CNT_W(CNT_W), .SEQ_W(SEQ_W)) u_sum (
    .evt_i       (sum_evt_i),
    .ready_cnt_i (ready_cnt_i),
    .iq_cnt_i    (iq_cnt_i),
    .lsq_cnt_i   (lsq_cnt_i),
    .iq_vld_i    (iq_old_vld_i),
    .iq_seq_i    (iq_old_seq_i),
    .iq_ops_i    (iq_old_ops_i),
    .iq_blame_i  (iq_old_blame_i),
    .lsq_vld_i   (lsq_old_vld_i),
    .lsq_seq_i   (lsq_old_seq_i),
    .lsq_ops_i   (lsq_old_ops_i),
    .lsq_blame_i (lsq_old_blame_i),
    .hit_o       (sum_hit),
    .cause_o     (sum_cause)
  );

  for (genvar g = 0; g < NUM_Q; g++) begin : g_q
    issue_loss_queue u_q (
      .evt_i      (q_evt_i[g]),
      .rdy_ne_i   (q_rdy_ne_i[g]),
      .bw_avail_i (q_bw_avail_i[g]),
      .win_ne_i   (q_win_ne_i[g]),
      .blame_i    (q_blame_i[g]),
      .prop_vld_o (prop_vld[g]),
      .prop_o     (prop[g])
    );
  end

  // Summary assigns directly; everything after it is first-wins
  always_comb begin
    stg[0] = cycle_start_i ? CAUSE_NONE : cur_q;
    if (sum_hit) stg[0] = sum_cause;
    for (int i = 0; i < NUM_Q; i++) begin
      stg[i+1] = (stg[i] == CAUSE_NONE && prop_vld[i]) ? prop[i] : stg[i];
    end
    nxt = (stg[NUM_Q] == CAUSE_NONE && thr_bw_i) ? CAUSE_BW : stg[NUM_Q];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q         <= CAUSE_NONE;
      cause_o       <= 3'd0;
      cause_valid_o <= 1'b0;
    end else begin
      cur_q         <= nxt;
      cause_valid_o <= cycle_end_i;
      if (cycle_end_i) cause_o <= nxt;
    end
  end

  a_r1_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cycle_end_i |=> cause_valid_o);
  a_r1_valid_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cycle_end_i |=> !cause_valid_o);
  a_r1_legal_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cause_o <= 3'd4);
  a_r10_first_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_q != CAUSE_NONE && !cycle_start_i && !sum_hit) |=> cur_q == $past(cur_q));
  a_r2_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cycle_start_i && !sum_evt_i && q_evt_i == '0 && !thr_bw_i) |=> cur_q == CAUSE_NONE);
  a_r3_empty_noins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sum_evt_i && ready_cnt_i == '0 && iq_cnt_i == '0 && lsq_cnt_i == '0)
    |=> cur_q == CAUSE_NOINS);
endmodule

// File: tb/tb_issue_loss_cause.sv
`timescale 1ns/1ps
module tb_issue_loss_cause;
  localparam int NQ = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs, ce, sev, iqv, iqo, iqb, lv, lo, lb, tbw;
  logic [3:0] rdy, iqc, lqc;
  logic [7:0] iqs, ls;
  logic [NQ-1:0] qe, qr, qbw, qw, qb;
  logic [2:0] cause;
  logic cvld;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  issue_loss_cause #(.NUM_Q(NQ), .CNT_W(4), .SEQ_W(8)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cycle_start_i(cs), .cycle_end_i(ce),
    .sum_evt_i(sev), .ready_cnt_i(rdy), .iq_cnt_i(iqc), .lsq_cnt_i(lqc),
    .iq_old_vld_i(iqv), .iq_old_seq_i(iqs), .iq_old_ops_i(iqo), .iq_old_blame_i(iqb),
    .lsq_old_vld_i(lv), .lsq_old_seq_i(ls), .lsq_old_ops_i(lo), .lsq_old_blame_i(lb),
    .q_evt_i(qe), .q_rdy_ne_i(qr), .q_bw_avail_i(qbw), .q_win_ne_i(qw), .q_blame_i(qb),
    .thr_bw_i(tbw), .cause_o(cause), .cause_valid_o(cvld));

  typedef struct packed {
    bit [23:0] tag;
    bit sum; bit [3:0] rdy, iqc, lqc;
    bit iqv; bit [7:0] iqs; bit iqo, iqb;
    bit lv;  bit [7:0] ls;  bit lo, lb;
    bit [1:0] qe, qr, qbw, qw, qb;
    bit tbw; bit [2:0] exp;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [0:NV-1] = '{
    '{"R3", 1,0,0,0, 0,0,0,0, 0,0,0,0, 2'b00,2'b00,2'b00,2'b00,2'b00, 0, 3'd1},
    '{"R4", 1,0,2,1, 1,10,1,0, 1,5,0,0, 2'b00,2'b00,2'b00,2'b00,2'b00, 0, 3'd2},
    '{"R5", 1,0,2,1, 1,10,1,0, 1,5,0,1, 2'b00,2'b00,2'b00,2'b00,2'b00, 0, 3'd3},
    '{"R4", 1,0,1,1, 1,7,1,0, 1,7,0,1, 2'b00,2'b00,2'b00,2'b00,2'b00, 0, 3'd2},
    '{"R4", 1,0,0,1, 0,0,0,0, 1,9,0,1, 2'b00,2'b00,2'b00,2'b00,2'b00, 0, 3'd3},
    '{"R5", 1,0,1,1, 1,3,0,0, 1,9,1,0, 2'b00,2'b00,2'b00,2'b00,2'b00, 0, 3'd2},
    '{"R5", 1,0,1,1, 1,3,0,1, 1,9,1,0, 2'b00,2'b00,2'b00,2'b00,2'b00, 0, 3'd3},
    '{"R6", 1,2,1,1, 1,3,0,1, 1,9,1,0, 2'b00,2'b00,2'b00,2'b00,2'b00, 0, 3'd0},
    '{"R7", 0,0,0,0, 0,0,0,0, 0,0,0,0, 2'b01,2'b01,2'b00,2'b00,2'b00, 0, 3'd4},
    '{"R8", 0,0,0,0, 0,0,0,0, 0,0,0,0, 2'b01,2'b00,2'b00,2'b00,2'b00, 0, 3'd1},
    '{"R8", 0,0,0,0, 0,0,0,0, 0,0,0,0, 2'b01,2'b00,2'b01,2'b00,2'b00, 0, 3'd1},
    '{"R9", 0,0,0,0, 0,0,0,0, 0,0,0,0, 2'b01,2'b00,2'b01,2'b01,2'b01, 0, 3'd3},
    '{"R9", 0,0,0,0, 0,0,0,0, 0,0,0,0, 2'b01,2'b00,2'b01,2'b01,2'b00, 0, 3'd2},
    '{"R7", 0,0,0,0, 0,0,0,0, 0,0,0,0, 2'b01,2'b01,2'b01,2'b00,2'b00, 0, 3'd0},
    '{"R10",0,0,0,0, 0,0,0,0, 0,0,0,0, 2'b11,2'b10,2'b01,2'b00,2'b00, 0, 3'd1},
    '{"R10",0,0,0,0, 0,0,0,0, 0,0,0,0, 2'b10,2'b10,2'b01,2'b00,2'b00, 0, 3'd4},
    '{"R11",0,0,0,0, 0,0,0,0, 0,0,0,0, 2'b00,2'b00,2'b00,2'b00,2'b00, 1, 3'd4},
    '{"R10",1,0,2,1, 1,10,1,0, 1,5,0,1, 2'b01,2'b01,2'b00,2'b00,2'b00, 0, 3'd3},
    '{"R10",0,0,0,0, 0,0,0,0, 0,0,0,0, 2'b11,2'b01,2'b10,2'b10,2'b10, 0, 3'd4},
    '{"R6", 1,3,0,0, 0,0,0,0, 0,0,0,0, 2'b01,2'b00,2'b00,2'b00,2'b00, 0, 3'd1}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle();
    cs = 0; ce = 0; sev = 0; rdy = 0; iqc = 0; lqc = 0;
    iqv = 0; iqs = 0; iqo = 0; iqb = 0; lv = 0; ls = 0; lo = 0; lb = 0;
    qe = 0; qr = 0; qbw = 0; qw = 0; qb = 0; tbw = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
    idle();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk("R1 reset cause", cause, 0);
    chk("R1 reset valid", cvld, 0);

    for (int i = 0; i < NV; i++) begin
      cs = 1; ce = 1;
      sev = VEC[i].sum; rdy = VEC[i].rdy; iqc = VEC[i].iqc; lqc = VEC[i].lqc;
      iqv = VEC[i].iqv; iqs = VEC[i].iqs; iqo = VEC[i].iqo; iqb = VEC[i].iqb;
      lv = VEC[i].lv; ls = VEC[i].ls; lo = VEC[i].lo; lb = VEC[i].lb;
      qe = VEC[i].qe; qr = VEC[i].qr; qbw = VEC[i].qbw; qw = VEC[i].qw; qb = VEC[i].qb;
      tbw = VEC[i].tbw;
      tick();
      chk($sformatf("%s vector %0d", VEC[i].tag, i), cause, VEC[i].exp);
      chk($sformatf("R1 valid vector %0d", i), cvld, 1);
    end

    // R10: cause built over several clocks, first one kept
    cs = 1; tick();
    chk("R1 valid low without end", cvld, 0);
    qe = 2'b01; qr = 2'b01; tick();
    qe = 2'b10; tick();
    ce = 1; tick();
    chk("R10 multi-clock first wins", cause, 4);
    tick();
    chk("R1 valid single cycle", cvld, 0);
    chk("R1 cause holds", cause, 4);

    // R5: summary overwrites an existing cause
    cs = 1; tick();
    tbw = 1; tick();
    sev = 1; tick();
    ce = 1; tick();
    chk("R5 summary overwrites", cause, 1);

    // R2: start clears a stale cause
    tbw = 1; tick();
    cs = 1; tick();
    ce = 1; tick();
    chk("R2 start clears", cause, 0);

    // R2: start and event in one clock keeps the event
    tbw = 1; tick();
    cs = 1; ce = 1; qe = 2'b01; tick();
    chk("R2 start then same-clock event", cause, 1);

    finish_run();
  end
endmodule